// File: doc/BRIEF.md
# Digital Loss-of-Signal Detector

This block watches a dual-rail receive stream that delivers one bit per cycle of the recovered receive clock. A bit counts as a mark when either rail is high. When the stream goes silent for too long, the block raises a loss-of-signal flag. The silence limit depends on the line rate: a long limit for the 1.544 Mbit/s rate and a short limit for the 2.048 Mbit/s (E1) rate. The flag clears only when the stream shows enough marks again, measured over a sliding window of recent bits. This hysteresis stops the flag from chattering.

An external analog amplitude detector can also raise the flag. Its input is synchronised into the receive clock domain and ORed with the digital detector. During full local loopback that input is masked, so only the digital detector speaks. While the flag is set, a glitch-free two-clock multiplexer drives a clean reference clock on the output in place of the recovered clock. Downstream logic that is slaved to the line clock therefore keeps running.

Top module: `los_detector`

## Requirements
- R1: After reset `los` is high, and `clk_out` follows `clk_ref` once the clock hand-over has settled.
- R2: With `rate_e1` = 0, `los` rises at the `clk_rx` rising edge that samples the 128th consecutive zero bit, and not after 127. The zero-run count saturates, so a longer run keeps `los` high.
- R3: With `rate_e1` = 1, `los` rises at the `clk_rx` rising edge that samples the 32nd consecutive zero bit, and not after 31.
- R4: A set digital flag clears at the edge where the last 32 sampled bits, the current one included, hold at least four marks. It never clears while that window holds fewer than four.
- R5: A bit is a mark when `rx_pos` is high, `rx_neg` is high, or both are high. It is a zero only when both rails are low.
- R6: With `full_loop` = 0, a high `ana_los` forces `los` high from the second `clk_rx` rising edge after it is applied, whatever the digital state.
- R7: With `full_loop` = 1, `ana_los` has no effect, and `los` equals the digital detector.
- R8: `clk_out` follows `clk_ref` while `los` is high and `clk_rx` while `los` is low, after a hand-over of a few cycles of each clock.
- R9: `clk_out` never shows a high or low phase shorter than the shortest phase of the two input clocks, and the two clock enables are never high together.
- R10: The threshold is compared against the run already in progress. Switching from the long limit to the short limit after 31 or more zeros raises `los` on the next zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_rx | input | 1 | Recovered receive clock; one bit is sampled per rising edge |
| clk_ref | input | 1 | Jitter-free reference clock substituted on alarm |
| rst_n | input | 1 | Synchronous active-low reset, held for several cycles of both clocks |
| rate_e1 | input | 1 | 0 selects the 128-zero limit, 1 selects the 32-zero limit |
| full_loop | input | 1 | High during full local loopback; masks the analog input |
| rx_pos | input | 1 | Positive receive rail |
| rx_neg | input | 1 | Negative receive rail |
| ana_los | input | 1 | Analog amplitude detector output, asynchronous |
| los | output | 1 | Loss-of-signal flag |
| clk_out | output | 1 | Receive clock for downstream logic, recovered or reference |

## Verification
An off-by-one error in the zero-run counter would move the rising edge of `los` by one bit. The bench therefore checks every bit edge against a count computed from the stream, including the 127/128 and 31/32 boundaries. A wrong ones count in the window, for example a missing subtraction of the bit that leaves it, would show up within 32 bits of a sparse-mark sweep: `los` would clear at a mark spacing that should keep it set. A fault in the clock hand-over shows up within a dozen receive cycles as `clk_out` tracking the wrong clock, or as a runt phase shorter than 4 ns.

// File: rtl/los_pkg.sv
// Package: shared types for the loss-of-signal detector.
// Assumes: nothing beyond IEEE 1800-2017.
package los_pkg;

    // Line rate selection; the encoding matches the rate_e1 pin.
    typedef enum logic {
        RATE_T1 = 1'b0,
        RATE_E1 = 1'b1
    } rate_e;

    // Width needed to hold the values 0..max_val inclusive.
    function automatic int unsigned cnt_width(input int unsigned max_val);
        return $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/los_sync.sv
// Module: multi-stage synchroniser for a single bit.
// What it does: carries an asynchronous level into the clk domain through
// STAGES flops; NEG_EDGE picks the sampling edge.
// Assumes: STAGES >= 2; rst_n is synchronous to clk and held several cycles.
module los_sync #(
    parameter int STAGES   = 2,
    parameter bit NEG_EDGE = 1'b0,
    parameter bit RST_VAL  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    // Next value of the chain: shift in the asynchronous level.
    assign chain_d = {chain_q[STAGES-2:0], d};

    generate
        if (NEG_EDGE) begin : g_neg
            // Chain update on the falling edge.
            always_ff @(negedge clk) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= chain_d;
            end
        end else begin : g_pos
            // Chain update on the rising edge.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= chain_d;
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/los_zero_run.sv
// Module: saturating counter of consecutive zero bits.
// What it does: counts zero bits since the last mark, saturating at
// LONG_RUN, and reports when the count including the current bit reaches
// the threshold chosen by the rate select.
// Assumes: SHORT_RUN <= LONG_RUN; reset leaves the count saturated.
module los_zero_run
    import los_pkg::*;
#(
    parameter int LONG_RUN  = 128,
    parameter int SHORT_RUN = 32,
    localparam int RUN_W    = cnt_width(LONG_RUN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mark,
    input  rate_e            rate,
    output logic [RUN_W-1:0] run_q,
    output logic             run_hit
);

    localparam logic [RUN_W-1:0] LONG_C  = RUN_W'(LONG_RUN);
    localparam logic [RUN_W-1:0] SHORT_C = RUN_W'(SHORT_RUN);

    logic [RUN_W-1:0] run_nxt;
    logic [RUN_W-1:0] thr;

    // Next run length and threshold compare for the bit being sampled.
    always_comb begin
        if (mark)                 run_nxt = '0;
        else if (run_q >= LONG_C) run_nxt = LONG_C;
        else                      run_nxt = run_q + 1'b1;
        thr     = (rate == RATE_E1) ? SHORT_C : LONG_C;
        run_hit = (run_nxt >= thr);
    end

    // Run length register; starts saturated.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= LONG_C;
        else        run_q <= run_nxt;
    end

endmodule

// File: rtl/los_ones_window.sv
// Module: sliding-window mark counter.
// What it does: keeps the last WIN_LEN bits in a shift register together
// with a running count of marks, and flags when the count including the
// current bit reaches ONES_MIN.
// Assumes: ONES_MIN <= WIN_LEN; reset empties the window.
module los_ones_window
    import los_pkg::*;
#(
    parameter int WIN_LEN  = 32,
    parameter int ONES_MIN = 4,
    localparam int CNT_W   = cnt_width(WIN_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mark,
    output logic [CNT_W-1:0] ones_q,
    output logic             ones_hit
);

    localparam logic [CNT_W-1:0] MIN_C = CNT_W'(ONES_MIN);

    logic [WIN_LEN-1:0] hist_q;
    logic [WIN_LEN-1:0] hist_nxt;
    logic [CNT_W-1:0]   ones_nxt;

    // Window contents and count after taking in the current bit.
    always_comb begin
        hist_nxt = {hist_q[WIN_LEN-2:0], mark};
        ones_nxt = ones_q + CNT_W'(mark) - CNT_W'(hist_q[WIN_LEN-1]);
        ones_hit = (ones_nxt >= MIN_C);
    end

    // Window and running count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
            ones_q <= '0;
        end else begin
            hist_q <= hist_nxt;
            ones_q <= ones_nxt;
        end
    end

endmodule

// File: rtl/los_clk_switch.sv
// Module: glitch-free two-clock multiplexer.
// What it does: passes clk_a while sel_b is low and clk_b while it is high.
// Each side enables itself only after seeing the other side disabled, and
// changes its enable on its own falling edge, so no runt phase is produced.
// Assumes: sel_b holds for several cycles of both clocks; both clocks run.
module los_clk_switch #(
    parameter int STAGES = 2
) (
    input  logic clk_a,
    input  logic clk_b,
    input  logic rst_n,
    input  logic sel_b,
    output logic clk_o,
    output logic en_a,
    output logic en_b
);

    logic req_a;
    logic req_b;

    // Enable requests, each interlocked with the opposite enable.
    assign req_a = ~sel_b & ~en_b;
    assign req_b =  sel_b & ~en_a;

    los_sync #(.STAGES(STAGES), .NEG_EDGE(1'b1), .RST_VAL(1'b0)) u_sync_a (
        .clk   (clk_a),
        .rst_n (rst_n),
        .d     (req_a),
        .q     (en_a)
    );

    los_sync #(.STAGES(STAGES), .NEG_EDGE(1'b1), .RST_VAL(1'b0)) u_sync_b (
        .clk   (clk_b),
        .rst_n (rst_n),
        .d     (req_b),
        .q     (en_b)
    );

    // Gated combination; at most one enable is high at any time.
    assign clk_o = (clk_a & en_a) | (clk_b & en_b);

endmodule

// File: rtl/los_detector.sv
// Module: digital loss-of-signal detector (top).
// What it does: samples the dual-rail stream on clk_rx, sets a flag on a
// long zero run (rate dependent), clears it on enough marks in a sliding
// window, ORs in a synchronised analog detector unless in full local
// loopback, and substitutes clk_ref for clk_rx on clk_out while flagged.
// Assumes: rate_e1 and full_loop are quasi-static; rst_n spans both clocks.
module los_detector
    import los_pkg::*;
#(
    parameter int LONG_RUN    = 128,
    parameter int SHORT_RUN   = 32,
    parameter int WIN_LEN     = 32,
    parameter int ONES_MIN    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_rx,
    input  logic clk_ref,
    input  logic rst_n,
    input  logic rate_e1,
    input  logic full_loop,
    input  logic rx_pos,
    input  logic rx_neg,
    input  logic ana_los,
    output logic los,
    output logic clk_out
);

    localparam int RUN_W = cnt_width(LONG_RUN);
    localparam int CNT_W = cnt_width(WIN_LEN);

    rate_e            rate;
    logic             mark;
    logic [RUN_W-1:0] run_cnt;
    logic             run_hit;
    logic [CNT_W-1:0] ones_cnt;
    logic             ones_hit;
    logic             dig_q;
    logic             ana_s;
    logic             en_rx;
    logic             en_ref;

    // A bit is a mark when either rail is high.
    assign mark = rx_pos | rx_neg;
    assign rate = rate_e'(rate_e1);

    los_zero_run #(.LONG_RUN(LONG_RUN), .SHORT_RUN(SHORT_RUN)) u_run (
        .clk     (clk_rx),
        .rst_n   (rst_n),
        .mark    (mark),
        .rate    (rate),
        .run_q   (run_cnt),
        .run_hit (run_hit)
    );

    los_ones_window #(.WIN_LEN(WIN_LEN), .ONES_MIN(ONES_MIN)) u_win (
        .clk      (clk_rx),
        .rst_n    (rst_n),
        .mark     (mark),
        .ones_q   (ones_cnt),
        .ones_hit (ones_hit)
    );

    // Digital flag: set on a zero run, clear on mark density.
    always_ff @(posedge clk_rx) begin
        if (!rst_n)                dig_q <= 1'b1;
        else if (!dig_q && run_hit) dig_q <= 1'b1;
        else if (dig_q && ones_hit) dig_q <= 1'b0;
    end

    los_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b0), .RST_VAL(1'b0)) u_ana (
        .clk   (clk_rx),
        .rst_n (rst_n),
        .d     (ana_los),
        .q     (ana_s)
    );

    // Output flag: analog input is masked in full local loopback.
    assign los = dig_q | (ana_s & ~full_loop);

    los_clk_switch #(.STAGES(SYNC_STAGES)) u_clk (
        .clk_a (clk_rx),
        .clk_b (clk_ref),
        .rst_n (rst_n),
        .sel_b (los),
        .clk_o (clk_out),
        .en_a  (en_rx),
        .en_b  (en_ref)
    );

endmodule

// File: rtl/los_detector_chk.sv
// Module: property checker for los_detector, attached by bind.
// What it does: relates the counters, the digital flag and the clock
// enables over time.
// Assumes: connected to the internal signals named in the bind below.
module los_detector_chk #(
    parameter int LONG_RUN  = 128,
    parameter int SHORT_RUN = 32,
    parameter int WIN_LEN   = 32,
    parameter int ONES_MIN  = 4,
    parameter int RUN_W     = 8,
    parameter int CNT_W     = 6
) (
    input logic             clk_rx,
    input logic             clk_ref,
    input logic             rst_n,
    input logic             rate_e1,
    input logic             mark,
    input logic [RUN_W-1:0] run_cnt,
    input logic [CNT_W-1:0] ones_cnt,
    input logic             dig_q,
    input logic             en_rx,
    input logic             en_ref
);

    // R1: first edge out of reset sees the flag set.
    assert_reset_flag_R1: assert property (@(posedge clk_rx) disable iff (!rst_n)
        $past(!rst_n) |-> dig_q);

    // R2: long limit reached on a zero bit sets the flag.
    assert_set_long_R2: assert property (@(posedge clk_rx) disable iff (!rst_n)
        (!rate_e1 && !dig_q && !mark && int'(run_cnt) >= LONG_RUN - 1) |=> dig_q);

    // R2: run counter saturates.
    assert_run_sat_R2: assert property (@(posedge clk_rx) disable iff (!rst_n)
        int'(run_cnt) <= LONG_RUN);

    // R3: short limit reached on a zero bit sets the flag.
    assert_set_short_R3: assert property (@(posedge clk_rx) disable iff (!rst_n)
        (rate_e1 && !dig_q && !mark && int'(run_cnt) >= SHORT_RUN - 1) |=> dig_q);

    // R4: too few marks in the window keeps the flag.
    assert_hold_R4: assert property (@(posedge clk_rx) disable iff (!rst_n)
        (dig_q && int'(ones_cnt) < ONES_MIN - 1) |=> dig_q);

    // R4: a release is always backed by enough marks.
    assert_release_R4: assert property (@(posedge clk_rx) disable iff (!rst_n)
        $fell(dig_q) |-> int'(ones_cnt) >= ONES_MIN);

    // R9: enables exclusive, seen from both clocks.
    assert_excl_rx_R9: assert property (@(posedge clk_rx) disable iff (!rst_n)
        $onehot0({en_rx, en_ref}));
    assert_excl_ref_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $onehot0({en_rx, en_ref}));

endmodule

bind los_detector los_detector_chk #(
    .LONG_RUN  (LONG_RUN),
    .SHORT_RUN (SHORT_RUN),
    .WIN_LEN   (WIN_LEN),
    .ONES_MIN  (ONES_MIN),
    .RUN_W     (RUN_W),
    .CNT_W     (CNT_W)
) u_chk (
    .clk_rx   (clk_rx),
    .clk_ref  (clk_ref),
    .rst_n    (rst_n),
    .rate_e1  (rate_e1),
    .mark     (mark),
    .run_cnt  (run_cnt),
    .ones_cnt (ones_cnt),
    .dig_q    (dig_q),
    .en_rx    (en_rx),
    .en_ref   (en_ref)
);

// File: tb/sim_los_detector.sv
// Bench: drives bits on the falling edge of clk_rx, samples 1 ns after the
// rising edge, and compares los with an arithmetic model of the rules.
module sim_los_detector;
    timeunit 1ns;
    timeprecision 100ps;

    logic clk_rx = 1'b0;
    logic clk_ref = 1'b0;
    logic rst_n = 1'b0;
    logic rate_e1 = 1'b0;
    logic full_loop = 1'b0;
    logic rx_pos = 1'b0;
    logic rx_neg = 1'b0;
    logic ana_los = 1'b0;
    logic los;
    logic clk_out;

    int n_chk = 0;
    int n_fail = 0;
    bit chk_en = 1'b1;
    bit done = 1'b0;

    // Reference model state.
    logic [31:0] m_hist = '0;
    int          m_run = 128;
    bit          m_flag = 1'b1;

    // Clock phase monitor.
    real last_t = 0.0;
    real min_ph = 1.0e9;
    bit  mon_on = 1'b0;

    los_detector u0 (
        .clk_rx    (clk_rx),
        .clk_ref   (clk_ref),
        .rst_n     (rst_n),
        .rate_e1   (rate_e1),
        .full_loop (full_loop),
        .rx_pos    (rx_pos),
        .rx_neg    (rx_neg),
        .ana_los   (ana_los),
        .los       (los),
        .clk_out   (clk_out)
    );

    always #4 clk_rx = ~clk_rx;
    always #6 clk_ref = ~clk_ref;

    always @(posedge clk_out or negedge clk_out) begin
        if (mon_on && last_t > 0.0 && ($realtime - last_t) < min_ph)
            min_ph = $realtime - last_t;
        last_t = $realtime;
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    // Drive one bit, let the design sample it, update the model, compare.
    task automatic push(input logic p, input logic n);
        bit    prev;
        bit    m;
        int    thr;
        string tag;
        @(negedge clk_rx);
        rx_pos = p;
        rx_neg = n;
        @(posedge clk_rx);
        m      = p | n;
        prev   = m_flag;
        m_run  = m ? 0 : ((m_run < 128) ? m_run + 1 : 128);
        m_hist = {m_hist[30:0], m};
        thr    = rate_e1 ? 32 : 128;
        if (!m_flag && m_run >= thr)                   m_flag = 1'b1;
        else if (m_flag && $countones(m_hist) >= 4)    m_flag = 1'b0;
        if (m_flag != prev) tag = m_flag ? (rate_e1 ? "R3" : "R2") : "R4";
        else                tag = m_flag ? "R4" : (rate_e1 ? "R3" : "R2");
        #1;
        if (chk_en) chk(tag, los, m_flag);
    endtask

    task automatic zeros(input int cnt);
        for (int i = 0; i < cnt; i++) push(1'b0, 1'b0);
    endtask

    // Settle the hand-over, then compare clk_out with the expected clock.
    task automatic clk_check(input bit want_ref, input logic p, input logic n, input string tag);
        int bad = 0;
        for (int i = 0; i < 12; i++) push(p, n);
        for (int i = 0; i < 12; i++) begin
            push(p, n);
            for (int k = 0; k < 3; k++) begin
                #0.5;
                if (clk_out !== (want_ref ? clk_ref : clk_rx)) bad++;
                #0.5;
            end
        end
        n_chk++;
        if (bad != 0) begin
            n_fail++;
            $display("FAIL %s clock source: actual %0d mismatches expected 0", tag, bad);
        end
    endtask

    // Marks every `spacing` bits, rails rotating pos / neg / both.
    task automatic sweep(input int spacing, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            if (i % spacing == 0) begin
                case ((i / spacing) % 3)
                    0:       push(1'b1, 1'b0);
                    1:       push(1'b0, 1'b1);
                    default: push(1'b1, 1'b1);
                endcase
            end else begin
                push(1'b0, 1'b0);
            end
        end
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (10) @(negedge clk_rx);
        rst_n = 1'b1;
        mon_on = 1'b1;
        #1;
        chk("R1", los, 1'b1);
        clk_check(1'b1, 1'b0, 1'b0, "R1");

        // R4 / R5: three marks keep the flag, the fourth (negative rail) clears it.
        push(1'b1, 1'b0); push(1'b0, 1'b0); push(1'b0, 1'b1); push(1'b0, 1'b0);
        push(1'b1, 1'b1);
        chk("R4", los, 1'b1);
        push(1'b0, 1'b0);
        push(1'b0, 1'b1);
        chk("R5", los, 1'b0);
        clk_check(1'b0, 1'b1, 1'b0, "R8");

        // R2: 127 zeros keep it low, the 128th sets it, more stay set.
        zeros(127);
        chk("R2", los, 1'b0);
        zeros(1);
        chk("R2", los, 1'b1);
        zeros(50);
        chk("R2", los, 1'b1);
        clk_check(1'b1, 1'b0, 1'b0, "R8");
        for (int i = 0; i < 4; i++) push(1'b1, 1'b0);
        chk("R4", los, 1'b0);

        // R10: switch to the short limit mid-run.
        zeros(31);
        chk("R10", los, 1'b0);
        rate_e1 = 1'b1;
        zeros(1);
        chk("R10", los, 1'b1);
        for (int i = 0; i < 4; i++) push(1'b1, 1'b1);

        // R3: short limit boundary.
        zeros(31);
        chk("R3", los, 1'b0);
        zeros(1);
        chk("R3", los, 1'b1);

        // Sweeps over mark spacing for both rates.
        for (int r = 0; r < 2; r++) begin
            rate_e1 = r[0];
            for (int s = 1; s <= 40; s++) sweep(s, 160);
        end
        rate_e1 = 1'b0;

        // R6 / R7: analog input, unmasked then masked.
        for (int i = 0; i < 8; i++) push(1'b1, 1'b0);
        chk("R6", los, 1'b0);
        chk_en = 1'b0;
        ana_los = 1'b1;
        push(1'b1, 1'b0);
        push(1'b1, 1'b0);
        chk("R6", los, 1'b1);
        full_loop = 1'b1;
        push(1'b1, 1'b0);
        chk("R7", los, 1'b0);
        for (int i = 0; i < 3; i++) push(1'b0, 1'b1);
        chk("R7", los, 1'b0);
        ana_los = 1'b0;
        full_loop = 1'b0;
        for (int i = 0; i < 3; i++) push(1'b1, 1'b0);
        chk_en = 1'b1;
        chk("R7", los, 1'b0);

        // R9: no clk_out phase shorter than the shortest input phase (4 ns).
        n_chk++;
        if (min_ph < 3.99) begin
            n_fail++;
            $display("FAIL R9 shortest clk_out phase: actual %0.2f ns expected >= 4.00 ns", min_ph);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule